// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into host buffers through a circular ring of descriptors. The descriptors live in a small internal descriptor RAM that the host reads and writes over a simple word port. Each descriptor has four words: status, control, buffer base address and next-descriptor index. Bytes arrive on a byte stream that carries a last-byte marker. The engine writes each byte into the current descriptor's buffer through a byte write port. When the frame ends, or the buffer fills, it writes back a status word that hands the descriptor to the host. It then follows the next-descriptor index.

Before a frame starts, the engine fetches and caches the current descriptor. If the host still owns that descriptor, the engine discards the incoming frame, signals that no buffer was available and stays on that descriptor. It keeps refusing frames until the host strobes the poll-demand input, which makes it re-read the descriptor. A frame larger than one buffer continues into the following descriptors. Only the closing fragment carries the length, the address-match flags and the error flags. Error and match information come in as inputs with the last byte; the engine does not check CRC or filter addresses.

Top module: `rx_desc_ring`

## Requirements
- R1: The engine writes frame bytes into a descriptor's buffer only when status bit 31 (owner) was 1 when it fetched that descriptor. Every status word it writes back has bit 31 equal to 0.
- R2: In the closing status word, bits 27:16 hold the total number of bytes delivered for the frame. This count includes the four CRC bytes.
- R3: Status bit 11 is set in the first descriptor of a frame and bit 10 in the last. A frame that fits in one buffer has both bits set.
- R4: In the closing status, bits 14, 13 and 12 are copied from rx_match[2] (multicast), rx_match[1] (broadcast) and rx_match[0] (unicast address). rx_match is sampled with the last byte.
- R5: rx_err[4:0] (runt, long, alignment, CRC, receive error) is sampled with the last byte and placed in status bits 6, 5, 4, 3 and 2. Bit 7 is set exactly when any of these bits is set.
- R6: Byte k of a buffer goes to address (buffer base + k). The buffer holds control[10:0] bytes. When it is full, the frame continues in the descriptor named by word 3, so the ring wraps through that index.
- R7: An intermediate fragment gets a status word with bit 31, bit 10, length, match and error fields all zero. Bit 11 is set only on the frame's first fragment.
- R8: If a frame arrives while the cached descriptor is host-owned, the engine accepts and discards every byte of it and makes no buffer writes. It raises buf_unavail for one cycle per dropped frame and stays on the same descriptor.
- R9: After a drop, the engine does not re-read the descriptor, even if the host has since returned it, until poll_demand is pulsed. After the pulse, it re-fetches the current descriptor.
- R10: irq_done pulses for one cycle after a status writeback whose control word has bit 23 set. It does not pulse for descriptors where bit 23 is clear.
- R11: The host port addresses word (index*4 + w), where w is 0 status, 1 control, 2 buffer base or 3 next index. Read data appears one cycle after the address.
- R12: During and right after reset, rx_ready, irq_done, buf_unavail and buf_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe into descriptor RAM |
| host_addr | input | IDX_W+2 | Host word address (index, word select) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one-cycle latency |
| poll_demand | input | 1 | Restart strobe for a stalled engine |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the final byte of the frame |
| rx_err | input | 5 | Error flags, valid with last byte |
| rx_match | input | 3 | Address-match type, valid with last byte |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| irq_done | output | 1 | Completion interrupt pulse |
| buf_unavail | output | 1 | Frame dropped: no buffer available |

## Verification
The bench targets the buffer boundary in a frame that spans three descriptors and wraps the ring. If the length or the first/last flags leaked into intermediate fragments, or if the wrap ignored the next index, status words or byte addresses would land wrong. It also targets the stall. A design that re-checked ownership without a poll would accept the second frame sent after the host returned the descriptor, and a design that wrote bytes while host-owned would corrupt the buffer. It also checks the error summary, the match bit placement and the interrupt gating, since any of them is easy to shift by one bit.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_FETCH,
    ST_READY,
    ST_RECV,
    ST_DROP,
    ST_WB
  } rxr_state_t;

  localparam int OWN_BIT   = 31;
  localparam int IRQ_BIT   = 23;
  localparam int SIZE_W    = 11;
  localparam int LEN_W     = 12;
  localparam int WORD_STAT = 0;
  localparam int WORD_CTRL = 1;
  localparam int WORD_BASE = 2;
  localparam int WORD_NEXT = 3;
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_rdata
);
  logic [31:0] mem [DEPTH];

  // engine port written last so it wins on a same-word collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/rxr_status_pack.sv
module rxr_status_pack #(
  parameter int LEN_W = 12
) (
  input  logic             first,
  input  logic             last,
  input  logic [LEN_W-1:0] len,
  input  logic [2:0]       match,
  input  logic [4:0]       err,
  output logic [31:0]      word
);
  always_comb begin
    word        = '0;
    word[31]    = 1'b0;
    word[27:16] = 12'(len);
    word[14:12] = match;
    word[11]    = first;
    word[10]    = last;
    word[6:2]   = err;
    word[7]     = |err;
  end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int BUF_AW   = 16,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int AW      = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              poll_demand,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [4:0]        rx_err,
  input  logic [2:0]        rx_match,
  output logic              rx_ready,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              irq_done,
  output logic              buf_unavail
);
  localparam int DEPTH = NUM_DESC * 4;

  rxr_state_t        state;
  logic [IDX_W-1:0]  cur;
  logic [2:0]        fcnt;
  logic              d_own;
  logic [31:0]       d_ctrl;
  logic [BUF_AW-1:0] d_base;
  logic [IDX_W-1:0]  d_next;
  logic              mid, frag_first, poll_pend;
  logic [SIZE_W-1:0] boff, nxt_off;
  logic [LEN_W-1:0]  flen, nxt_len;
  logic [31:0]       wb_word, pack_word, eng_rdata;
  logic              eng_we, accept, drop, take, buf_full;
  logic [AW-1:0]     eng_addr;

  assign eng_we   = (state == ST_WB);
  assign eng_addr = eng_we ? {cur, 2'(WORD_STAT)} : {cur, fcnt[1:0]};

  rxr_desc_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk),
    .a_we(host_we), .a_addr(host_addr), .a_wdata(host_wdata), .a_rdata(host_rdata),
    .b_we(eng_we), .b_addr(eng_addr), .b_wdata(wb_word), .b_rdata(eng_rdata)
  );

  assign accept   = (state == ST_RECV) || (state == ST_READY && d_own && !poll_pend);
  assign drop     = (state == ST_DROP) || (state == ST_READY && !d_own && !poll_pend);
  assign rx_ready = accept || drop;
  assign take     = accept && rx_valid;

  assign nxt_off  = boff + 1'b1;
  assign nxt_len  = flen + 1'b1;
  assign buf_full = (nxt_off == d_ctrl[SIZE_W-1:0]);

  assign buf_we    = take;
  assign buf_addr  = d_base + BUF_AW'(boff);
  assign buf_wdata = rx_data;

  rxr_status_pack #(.LEN_W(LEN_W)) u_pack (
    .first(frag_first),
    .last (rx_last),
    .len  (rx_last ? nxt_len : '0),
    .match(rx_last ? rx_match : 3'b000),
    .err  (rx_last ? rx_err : 5'b00000),
    .word (pack_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FETCH;
      cur         <= '0;
      fcnt        <= '0;
      d_own       <= 1'b0;
      d_ctrl      <= '0;
      d_base      <= '0;
      d_next      <= '0;
      mid         <= 1'b0;
      frag_first  <= 1'b1;
      poll_pend   <= 1'b0;
      boff        <= '0;
      flen        <= '0;
      wb_word     <= '0;
      irq_done    <= 1'b0;
      buf_unavail <= 1'b0;
    end else begin
      irq_done    <= 1'b0;
      buf_unavail <= 1'b0;
      case (state)
        ST_FETCH: begin
          fcnt <= fcnt + 1'b1;
          case (fcnt)
            3'd1: d_own  <= eng_rdata[OWN_BIT];
            3'd2: d_ctrl <= eng_rdata;
            3'd3: d_base <= eng_rdata[BUF_AW-1:0];
            3'd4: begin
              d_next     <= eng_rdata[IDX_W-1:0];
              boff       <= '0;
              frag_first <= !mid;
              if (!mid) flen <= '0;
              if (mid && !d_own) begin
                state       <= ST_DROP;
                buf_unavail <= 1'b1;
                mid         <= 1'b0;
              end else begin
                state <= ST_READY;
              end
            end
            default: ;
          endcase
        end
        ST_READY: begin
          if (poll_pend) begin
            state     <= ST_FETCH;
            fcnt      <= '0;
            poll_pend <= 1'b0;
          end else if (rx_valid && !d_own) begin
            buf_unavail <= 1'b1;
            if (!rx_last) state <= ST_DROP;
          end
        end
        ST_DROP: if (rx_valid && rx_last) state <= ST_READY;
        ST_WB: begin
          irq_done <= d_ctrl[IRQ_BIT];
          cur      <= d_next;
          fcnt     <= '0;
          state    <= ST_FETCH;
        end
        default: ;
      endcase
      if (take) begin
        boff    <= nxt_off;
        flen    <= nxt_len;
        wb_word <= pack_word;
        if (rx_last) begin
          mid   <= 1'b0;
          state <= ST_WB;
        end else if (buf_full) begin
          mid   <= 1'b1;
          state <= ST_WB;
        end else begin
          state <= ST_RECV;
        end
      end
      if (poll_demand) poll_pend <= 1'b1;
    end
  end

  // R1
  own_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> !wb_word[OWN_BIT]);
  // R5
  err_summary_chk: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> (wb_word[7] == (|wb_word[6:2])));
  // R7
  frag_len_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_we && !wb_word[10]) |-> (wb_word[27:16] == 12'd0 && wb_word[7:2] == 6'd0));
  // R8
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP) |-> !buf_we);
  // R10
  irq_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> $past(eng_we));
endmodule

// File: tb/test_rx_desc_ring.sv
module test_rx_desc_ring;
  localparam int NUM_DESC = 4;
  localparam int BUF_AW   = 16;
  localparam int AW       = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic poll_demand = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_last = 1'b0;
  logic [4:0] rx_err = '0;
  logic [2:0] rx_match = '0;
  logic rx_ready, buf_we, irq_done, buf_unavail;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0] buf_wdata;

  int checks = 0;
  int failures = 0;
  int wr_count = 0;
  int irq_count = 0;
  int unav_count = 0;
  int cycles = 0;
  logic [7:0] tbm [2048];

  always #5 clk = ~clk;

  rx_desc_ring #(.NUM_DESC(NUM_DESC), .BUF_AW(BUF_AW)) i_rx_desc_ring (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .poll_demand(poll_demand),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err), .rx_match(rx_match),
    .rx_ready(rx_ready),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .irq_done(irq_done), .buf_unavail(buf_unavail)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (buf_we) begin
      tbm[buf_addr[10:0]] <= buf_wdata;
      wr_count <= wr_count + 1;
    end
    if (irq_done) irq_count <= irq_count + 1;
    if (buf_unavail) unav_count <= unav_count + 1;
  end

  always @(posedge clk) begin
    if (cycles == 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input int idx, input int w, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(idx * 4 + w); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input int idx, input int w, output logic [31:0] d);
    @(negedge clk);
    host_addr = AW'(idx * 4 + w);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] v0,
                            input logic [2:0] m, input logic [4:0] e);
    @(negedge clk);
    rx_match = m; rx_err = e;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = v0 + 8'(i); rx_last = (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    idle(12);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 rx_ready in reset", {31'd0, rx_ready}, 0);
    chk("R12 buf_we in reset", {31'd0, buf_we}, 0);
    chk("R12 pulses in reset", {30'd0, irq_done, buf_unavail}, 0);
  endtask

  task automatic t_single;
    logic [31:0] d;
    int ok;
    send_frame(6, 8'h10, 3'b001, 5'b00000);
    hread(0, 0, d);
    chk("R2 R3 R4 single status", d, 32'h0006_1C00);
    ok = 1;
    for (int i = 0; i < 6; i++) if (tbm[11'h100 + i] !== 8'h10 + 8'(i)) ok = 0;
    chk("R6 single buffer bytes", ok, 1);
    chk("R10 irq on bit23", irq_count, 1);
    hread(0, 1, d);
    chk("R11 control readback", d, 32'h0080_0040);
  endtask

  task automatic t_error;
    logic [31:0] d;
    send_frame(5, 8'h40, 3'b010, 5'b00010);
    hread(1, 0, d);
    chk("R5 R4 crc error status", d, 32'h0005_2C88);
    chk("R10 no irq without bit23", irq_count, 1);
  endtask

  task automatic t_multi;
    logic [31:0] d;
    int ok;
    hwrite(0, 0, 32'h8000_0000);
    send_frame(10, 8'h80, 3'b100, 5'b10000);
    hread(2, 0, d);
    chk("R7 R3 first fragment", d, 32'h0000_0800);
    hread(3, 0, d);
    chk("R7 middle fragment", d, 32'h0000_0000);
    hread(0, 0, d);
    chk("R2 R5 last fragment wrap", d, 32'h000A_44C0);
    ok = 1;
    for (int i = 0; i < 4; i++) begin
      if (tbm[11'h300 + i] !== 8'h80 + 8'(i)) ok = 0;
      if (tbm[11'h400 + i] !== 8'h84 + 8'(i)) ok = 0;
    end
    if (tbm[11'h100] !== 8'h88 || tbm[11'h101] !== 8'h89) ok = 0;
    chk("R6 chained buffer bytes", ok, 1);
    chk("R10 irq on wrapped desc", irq_count, 2);
  endtask

  task automatic t_stall;
    logic [31:0] d;
    int w0, u0;
    w0 = wr_count; u0 = unav_count;
    send_frame(3, 8'hA0, 3'b001, 5'b0);
    chk("R8 no buffer writes when host-owned", wr_count, w0);
    chk("R8 buf_unavail once", unav_count, u0 + 1);
    hread(1, 0, d);
    chk("R8 status untouched", d, 32'h0005_2C88);
    hwrite(1, 0, 32'h8000_0000);
    send_frame(3, 8'hB0, 3'b001, 5'b0);
    chk("R9 still stalled without poll", wr_count, w0);
    hread(1, 0, d);
    chk("R9 host status kept", d, 32'h8000_0000);
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
    idle(10);
    send_frame(4, 8'hC0, 3'b001, 5'b0);
    hread(1, 0, d);
    chk("R9 R1 frame after poll", d, 32'h0004_1C00);
    chk("R9 bytes after poll", {24'd0, tbm[11'h203]}, 32'h0000_00C3);
  endtask

  initial begin
    t_reset();
    hwrite(0, 0, 32'h8000_0000); hwrite(0, 1, 32'h0080_0040);
    hwrite(0, 2, 32'h0000_0100); hwrite(0, 3, 32'd1);
    hwrite(1, 0, 32'h8000_0000); hwrite(1, 1, 32'h0000_0040);
    hwrite(1, 2, 32'h0000_0200); hwrite(1, 3, 32'd2);
    hwrite(2, 0, 32'h8000_0000); hwrite(2, 1, 32'h0000_0004);
    hwrite(2, 2, 32'h0000_0300); hwrite(2, 3, 32'd3);
    hwrite(3, 0, 32'h8000_0000); hwrite(3, 1, 32'h0000_0004);
    hwrite(3, 2, 32'h0000_0400); hwrite(3, 3, 32'd0);
    @(negedge clk); rst = 1'b0;
    chk("R12 rx_ready after reset", {31'd0, rx_ready}, 0);
    idle(10);
    t_single();
    t_error();
    t_multi();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule